// File: doc/BRIEF.md
# Two-Pass Subranging Code Combiner

This block forms the final word of a two-pass subranging converter. The first pass yields a coarse code and the second pass yields a fine code. Each is captured into its own register when its strobe is asserted. The fine pass spans four coarse steps, so the two codes share two bits of weight. The block shifts the coarse code up, adds the fine code and removes a midscale bias. An error in the coarse decision of up to one coarse step, in either direction, is therefore absorbed by the fine code.

The sum is clamped to the output range. A clamp in either direction raises a range flag. A separate latch strobe moves the corrected word and the flag into a result register, which keeps its value until the next latch strobe. An active-low output enable controls a registered drive signal. While that drive signal is high, the data bus and the range flag carry the latched result; while it is low, both are released to high impedance. The output word is offset binary: midscale means zero input, all ones is one step below positive full scale, and all zeros is negative full scale.

Top module: `subrange_corrector`

## Requirements
- R1: After reset the drive signal `bus_en` is low and the result register holds midscale (0x2000) with the range flag clear. Once output is enabled, the bus shows 0x2000 and the flag reads 0.
- R2: On a latch strobe, the result register loads coarse*64 + fine - 128, computed from the captured codes, whenever that value lies in 0..16383. Example: coarse 128 with fine 128 gives 0x2000, which is zero in offset binary.
- R3: When the sum is below 0, the latched word is all zeros and the range flag is 1.
- R4: When the sum is above 16383, the latched word is all ones (0x3FFF) and the range flag is 1.
- R5: When the sum is in range, including exactly 0 and exactly 16383, the range flag is 0.
- R6: The result register and the flag keep their value in every cycle without a latch strobe, even when new codes are captured.
- R7: The coarse and fine capture registers load only on their own strobes. A latch strobe uses the most recently captured codes, not the live code inputs.
- R8: `bus_en` equals the inverse of `oe_n` as sampled at the previous clock edge. While `bus_en` is high, `data_out` and `range_out` show the latched result; while it is low, both are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_code | input | 8 | First-pass code |
| coarse_stb | input | 1 | Captures coarse_code |
| fine_code | input | 8 | Second-pass code |
| fine_stb | input | 1 | Captures fine_code |
| latch_stb | input | 1 | Loads the corrected word and flag into the result register |
| oe_n | input | 1 | Active-low output enable |
| data_out | output | 14 | Offset-binary result, tri-stated |
| range_out | output | 1 | Over/under-range flag, active high, tri-stated |
| bus_en | output | 1 | High while the outputs are driven |

## Verification
The clamp assertions treat the combiner's under and over signals as mutually exclusive. That holds only when the coarse and fine codes each fit their declared widths, so the stimulus drives only 8-bit values. The assertions also assume that the strobes and `oe_n` are synchronous and change only between clock edges. The bench therefore changes all inputs on the falling edge. It pulses each strobe in its own cycle, so every latch strobe sees codes that were captured in earlier cycles.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned SR_COARSE_W = 8;
  localparam int unsigned SR_FINE_W   = 8;
  localparam int unsigned SR_OVL_W    = 2;

  function automatic int unsigned sr_out_width(input int unsigned cw, input int unsigned fw,
                                               input int unsigned ow);
    return cw + fw - ow;
  endfunction
endpackage

// File: rtl/sr_code_capture.sv
module sr_code_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] code,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= MID;
    else if (stb) q <= code;
  end
endmodule

// File: rtl/sr_combine.sv
module sr_combine #(
  parameter int unsigned CW  = 8,
  parameter int unsigned FW  = 8,
  parameter int unsigned OVL = 2,
  parameter int unsigned OW  = CW + FW - OVL
) (
  input  logic [CW-1:0] coarse,
  input  logic [FW-1:0] fine,
  output logic [OW-1:0] value,
  output logic          under,
  output logic          over
);
  localparam int unsigned SHIFT  = FW - OVL;
  localparam int unsigned CALC_W = OW + 2;
  localparam logic signed [CALC_W-1:0] BIAS = CALC_W'(1) << (FW - 1);
  localparam logic signed [CALC_W-1:0] TOP  = (CALC_W'(1) << OW) - CALC_W'(1);

  // Weighted sum of the two passes minus the midscale bias
  function automatic logic signed [CALC_W-1:0] raw_sum(input logic [CW-1:0] c,
                                                       input logic [FW-1:0] f);
    logic signed [CALC_W-1:0] cx;
    logic signed [CALC_W-1:0] fx;
    cx = signed'(CALC_W'(c));
    fx = signed'(CALC_W'(f));
    return (cx <<< SHIFT) + fx - BIAS;
  endfunction

  function automatic logic [OW-1:0] clamp(input logic signed [CALC_W-1:0] r);
    if (r < 0)        return '0;
    else if (r > TOP) return '1;
    else              return r[OW-1:0];
  endfunction

  logic signed [CALC_W-1:0] raw;

  always_comb begin
    raw   = raw_sum(coarse, fine);
    under = (raw < 0);
    over  = (raw > TOP);
    value = clamp(raw);
  end
endmodule

// File: rtl/sr_result_reg.sv
module sr_result_reg #(
  parameter int unsigned OW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [OW-1:0] value,
  input  logic          clipped,
  output logic [OW-1:0] res_q,
  output logic          range_q
);
  localparam logic [OW-1:0] MID = OW'(1) << (OW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= MID;
      range_q <= 1'b0;
    end else if (load) begin
      res_q   <= value;
      range_q <= clipped;
    end
  end
endmodule

// File: rtl/sr_bus_drive.sv
module sr_bus_drive #(
  parameter int unsigned OW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe_n,
  input  logic [OW-1:0] res,
  input  logic          range_flag,
  output logic          bus_en,
  output logic [OW-1:0] data_out,
  output logic          range_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_en <= 1'b0;
    else        bus_en <= !oe_n;
  end

  assign data_out  = bus_en ? res : {OW{1'bz}};
  assign range_out = bus_en ? range_flag : 1'bz;
endmodule

// File: rtl/subrange_corrector.sv
module subrange_corrector
  import sr_pkg::*;
#(
  parameter int unsigned COARSE_W = SR_COARSE_W,
  parameter int unsigned FINE_W   = SR_FINE_W,
  parameter int unsigned OVL_W    = SR_OVL_W,
  parameter int unsigned OUT_W    = sr_out_width(COARSE_W, FINE_W, OVL_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COARSE_W-1:0] coarse_code,
  input  logic                coarse_stb,
  input  logic [FINE_W-1:0]   fine_code,
  input  logic                fine_stb,
  input  logic                latch_stb,
  input  logic                oe_n,
  output logic [OUT_W-1:0]    data_out,
  output logic                range_out,
  output logic                bus_en
);
  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine_q;
  logic [OUT_W-1:0]    sum_w;
  logic                under_w;
  logic                over_w;
  logic [OUT_W-1:0]    res_q;
  logic                range_q;

  sr_code_capture #(.W(COARSE_W)) u_coarse (
    .clk(clk), .rst_n(rst_n), .stb(coarse_stb), .code(coarse_code), .q(coarse_q)
  );

  sr_code_capture #(.W(FINE_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .stb(fine_stb), .code(fine_code), .q(fine_q)
  );

  sr_combine #(.CW(COARSE_W), .FW(FINE_W), .OVL(OVL_W), .OW(OUT_W)) u_comb (
    .coarse(coarse_q), .fine(fine_q), .value(sum_w), .under(under_w), .over(over_w)
  );

  sr_result_reg #(.OW(OUT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(latch_stb), .value(sum_w),
    .clipped(under_w | over_w), .res_q(res_q), .range_q(range_q)
  );

  sr_bus_drive #(.OW(OUT_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .res(res_q), .range_flag(range_q),
    .bus_en(bus_en), .data_out(data_out), .range_out(range_out)
  );
endmodule

// File: rtl/subrange_corrector_chk.sv
module subrange_corrector_chk #(
  parameter int unsigned OW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          latch_stb,
  input logic          oe_n,
  input logic          bus_en,
  input logic          under_w,
  input logic          over_w,
  input logic [OW-1:0] res_q,
  input logic          range_q
);
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && under_w) |=> (res_q == '0 && range_q)); // R3
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && over_w) |=> (res_q == '1 && range_q)); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && !under_w && !over_w) |=> !range_q); // R5
  AST_FLAG_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    range_q |-> (res_q == '0 || res_q == '1)); // R5
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> ($stable(res_q) && $stable(range_q))); // R6
  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> bus_en); // R8
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !bus_en); // R8
endmodule

bind subrange_corrector subrange_corrector_chk #(.OW(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .oe_n(oe_n), .bus_en(bus_en),
  .under_w(under_w), .over_w(over_w), .res_q(res_q), .range_q(range_q)
);

// File: tb/subrange_corrector_tb.sv
`timescale 1ns/1ps
module subrange_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  coarse_code = '0;
  logic        coarse_stb = 1'b0;
  logic [7:0]  fine_code = '0;
  logic        fine_stb = 1'b0;
  logic        latch_stb = 1'b0;
  logic        oe_n = 1'b1;
  wire  [13:0] data_out;
  wire         range_out;
  logic        bus_en;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  subrange_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .coarse_code(coarse_code), .coarse_stb(coarse_stb),
    .fine_code(fine_code), .fine_stb(fine_stb), .latch_stb(latch_stb), .oe_n(oe_n),
    .data_out(data_out), .range_out(range_out), .bus_en(bus_en)
  );

  function automatic void check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // Expected word and flag, restated from the requirements in plain integers
  function automatic int ref_word(input int c, input int f);
    int s = c * 64 + f - 128;
    if (s < 0) return 0;
    if (s > 16383) return 16383;
    return s;
  endfunction

  function automatic int ref_flag(input int c, input int f);
    int s = c * 64 + f - 128;
    return (s < 0 || s > 16383) ? 1 : 0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic capture_and_latch(input int c, input int f);
    coarse_code = 8'(c); coarse_stb = 1'b1; tick();
    coarse_stb = 1'b0; fine_code = 8'(f); fine_stb = 1'b1; tick();
    fine_stb = 1'b0; latch_stb = 1'b1; tick();
    latch_stb = 1'b0;
  endtask

  task automatic run_case(input string tag, input int c, input int f);
    capture_and_latch(c, f);
    check({tag, " word"}, int'(data_out), ref_word(c, f));
    check({tag, " flag"}, int'(range_out), ref_flag(c, f));
  endtask

  task automatic t_reset();
    tick(); tick();
    check("R1 bus_en after reset", int'(bus_en), 0);
    rst_n = 1'b1; tick();
    oe_n = 1'b0; tick();
    check("R1 bus_en enabled", int'(bus_en), 1);
    check("R1 midscale word", int'(data_out), 8192);
    check("R1 flag clear", int'(range_out), 0);
  endtask

  task automatic t_in_range();
    run_case("R2 midscale zero", 128, 128);
    run_case("R2 typical", 100, 37);
    run_case("R2 fine corrects upward", 3, 250);
    run_case("R2 fine corrects downward", 10, 5);
    run_case("R5 exact bottom", 0, 128);
    run_case("R5 exact top", 255, 191);
  endtask

  task automatic t_clamps();
    run_case("R3 just below zero", 0, 127);
    run_case("R3 deepest under", 0, 0);
    run_case("R4 just above top", 255, 192);
    run_case("R4 deepest over", 255, 255);
  endtask

  task automatic t_hold();
    capture_and_latch(50, 60);
    coarse_code = 8'd200; coarse_stb = 1'b1; tick();
    coarse_stb = 1'b0; fine_code = 8'd10; fine_stb = 1'b1; tick();
    fine_stb = 1'b0; tick(); tick();
    check("R6 word held", int'(data_out), ref_word(50, 60));
    check("R6 flag held", int'(range_out), 0);
    latch_stb = 1'b1; tick(); latch_stb = 1'b0;
    check("R6 word after latch", int'(data_out), ref_word(200, 10));
  endtask

  task automatic t_capture_gating();
    capture_and_latch(40, 100);
    coarse_code = 8'd41; coarse_stb = 1'b1; fine_code = 8'd0; tick();
    coarse_stb = 1'b0; fine_code = 8'd255; latch_stb = 1'b1; tick();
    latch_stb = 1'b0;
    check("R7 uses captured fine", int'(data_out), ref_word(41, 100));
  endtask

  task automatic t_output_enable();
    capture_and_latch(77, 77);
    oe_n = 1'b1; #1;
    check("R8 drive still on same cycle", int'(bus_en), 1);
    tick();
    check("R8 drive off next edge", int'(bus_en), 0);
    oe_n = 1'b0; #1;
    check("R8 drive still off same cycle", int'(bus_en), 0);
    tick();
    check("R8 drive on next edge", int'(bus_en), 1);
    check("R8 word visible", int'(data_out), ref_word(77, 77));
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_in_range();
    t_clamps();
    t_hold();
    t_capture_gating();
    t_output_enable();
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule